// File: doc/BRIEF.md
# Packet Sequence Loss Monitor

This block sits beside a packet receiver and inspects the header of every packet that arrives. Each header carries two sequence fields: a frame number that advances once per frame and a packet number that counts the packets inside that frame. Each frame is made of a fixed number of packets. By comparing each header with the numbers it expects next, the block tells apart two kinds of loss. A packet missing from a frame that still arrived is a partial loss and can be tolerated downstream. A frame of which no packet arrived at all is a complete frame loss.

The monitor keeps three saturating counters: lost packets, completely lost frames and frames received. It also gives a one-cycle loss pulse for every header that reveals a loss, and a one-cycle out-of-order pulse for a packet whose number lies behind the expected one in the current frame. Payload data, retransmission and reordering are handled elsewhere. A synchronous clear input zeroes the counters and re-arms the tracking, so the next header is taken as a fresh starting point.

Top module: `pkt_seq_monitor`

## Requirements
- R1: After reset all three counters read zero and both pulse outputs are low.
- R2: The first header accepted after reset or after a clear only sets the expected frame number to its frame and the expected packet number to its packet number plus one. It adds one to the received-frame counter and never counts a loss or raises a pulse, whatever its packet number.
- R3: A header whose frame number equals the tracked frame and whose packet number equals the expected packet number changes no counter and raises no pulse. A header with a frame number different from the tracked one adds exactly one to the received-frame counter.
- R4: Within the tracked frame, a packet number p greater than the expected value e adds p − e to the lost-packet counter. The loss pulse is high for exactly the one cycle after the clock edge that accepted that header, and the next expected value becomes p + 1.
- R5: When a new frame number appears, the lost-packet counter grows by the packets still missing at the end of the tracked frame (packets per frame minus the expected value) plus the packet number of the new header (the packets missing at the start of the new frame).
- R6: When a new frame number appears, the frame distance k is the new frame number minus the tracked one, modulo two to the power of the frame-field width. The lost-frame counter grows by k − 1. The loss pulse rises whenever R5 or R6 adds a non-zero amount.
- R7: A packet number below the expected value within the tracked frame raises the out-of-order pulse for one cycle. It changes no counter, raises no loss pulse, and leaves the expected frame and packet numbers unchanged.
- R8: Each counter stops at its all-ones value instead of wrapping, and it never decreases except on a clear.
- R9: A clear zeroes all counters on the next clock edge and re-arms the first-header behaviour of R2. A header presented in the same cycle as a clear is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of counters and tracking |
| hdr_valid | input | 1 | Header fields are valid this cycle |
| hdr_frame | input | FRAME_W | Frame number of the received packet |
| hdr_pkt | input | PKT_W | Packet number within the frame (below PKTS_PER_FRAME) |
| lost_pkt_cnt | output | CNT_W | Saturating count of missing packets within frames that arrived |
| lost_frame_cnt | output | CNT_W | Saturating count of frames with no packet received |
| rx_frame_cnt | output | CNT_W | Saturating count of frames with at least one packet received |
| loss_pulse | output | 1 | One-cycle pulse for a header that reveals a loss |
| ooo_pulse | output | 1 | One-cycle pulse for a backward packet number in the current frame |

## Verification
The bench runs a small configuration and sweeps every pairing of the last packet seen in one frame with the first packet seen in the next. A design that dropped the tail term or the leading term of R5, or that was off by one in either, would give the wrong lost-packet count in a specific cell of that sweep. Every skip distance within a frame is exercised, including a backward step followed by the expected packet. A design that reset its tracking on an out-of-order packet would then count a false loss. Frame jumps across the modular wrap of the frame field check that k − 1 frames are added, and small counters are driven into saturation to show that they hold at the top instead of wrapping. A first header with a non-zero packet number, and a header that arrives together with a clear, check that neither is counted.

// File: rtl/pkt_mon_pkg.sv
// Package: shared types for the packet sequence loss monitor.
// Assumes nothing beyond IEEE 1800-2017 enums.
package pkt_mon_pkg;

    // Classification of one accepted header against the tracked sequence.
    typedef enum logic [2:0] {
        CLS_IDLE     = 3'd0,  // no header accepted this cycle
        CLS_FIRST    = 3'd1,  // first header after reset or clear
        CLS_INORDER  = 3'd2,  // exactly the expected packet
        CLS_SKIP     = 3'd3,  // same frame, packets skipped
        CLS_NEWFRAME = 3'd4,  // a different frame number appeared
        CLS_OOO      = 3'd5   // same frame, number behind expectation
    } hdr_class_e;

endpackage

// File: rtl/pkt_sat_counter.sv
// Module: pkt_sat_counter
// Adds an unsigned increment to a counter each cycle and stops at the
// all-ones value instead of wrapping. A synchronous clear or reset zeroes it.
// Assumes the increment is zero in cycles with nothing to count.
module pkt_sat_counter #(
    parameter int CNT_W = 16,
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] cnt
);
    localparam int SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W-1:0] sum;

    // Wide sum so that an overflow is visible before it is clipped.
    assign sum = SUM_W'(cnt_q) + SUM_W'(inc);

    // Counter register: clear wins, otherwise clipped accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (sum > SUM_W'(CNT_MAX)) begin
            cnt_q <= CNT_MAX;
        end else begin
            cnt_q <= sum[CNT_W-1:0];
        end
    end

    assign cnt = cnt_q;

    // R8: a full counter stays full unless cleared.
    p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

    // R8: the count never goes down without a clear.
    p_monotonic_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt_q >= $past(cnt_q));

    // R9: a clear leaves the counter at zero.
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);

endmodule

// File: rtl/pkt_seq_tracker.sv
// Module: pkt_seq_tracker
// Holds the expected frame and packet numbers and classifies every
// accepted header. Produces per-header increments for the loss counters
// and registered one-cycle loss and out-of-order pulses.
// Assumes hdr_pkt is always below PKTS_PER_FRAME, and that
// PKTS_PER_FRAME < 2**PKT_W so that the expected value fits PKT_W+1 bits.
module pkt_seq_tracker
    import pkt_mon_pkg::*;
#(
    parameter int FRAME_W        = 16,
    parameter int PKT_W          = 9,
    parameter int PKTS_PER_FRAME = 270
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               hdr_valid,
    input  logic [FRAME_W-1:0] hdr_frame,
    input  logic [PKT_W-1:0]   hdr_pkt,
    output logic [PKT_W:0]     pkt_inc,
    output logic [FRAME_W-1:0] frm_inc,
    output logic               rx_inc,
    output logic               loss_q,
    output logic               ooo_q
);
    localparam logic [PKT_W:0] PKTS_V = PKTS_PER_FRAME[PKT_W:0];

    logic               armed_q;
    logic [FRAME_W-1:0] frame_q;
    logic [PKT_W:0]     exp_q;
    logic [PKT_W:0]     pkt_ext;
    logic [FRAME_W-1:0] frame_diff;
    hdr_class_e         cls;

    assign pkt_ext    = {1'b0, hdr_pkt};
    assign frame_diff = hdr_frame - frame_q;

    // Classify the header and derive the counter increments.
    always_comb begin
        cls     = CLS_IDLE;
        pkt_inc = '0;
        frm_inc = '0;
        rx_inc  = 1'b0;
        if (hdr_valid && !clr) begin
            if (!armed_q) begin
                cls    = CLS_FIRST;
                rx_inc = 1'b1;
            end else if (frame_diff == '0) begin
                if (pkt_ext == exp_q) begin
                    cls = CLS_INORDER;
                end else if (pkt_ext > exp_q) begin
                    cls     = CLS_SKIP;
                    pkt_inc = pkt_ext - exp_q;
                end else begin
                    cls = CLS_OOO;
                end
            end else begin
                cls     = CLS_NEWFRAME;
                rx_inc  = 1'b1;
                pkt_inc = (PKTS_V - exp_q) + pkt_ext;
                frm_inc = frame_diff - FRAME_W'(1);
            end
        end
    end

    // Tracking state: re-armed by clear, untouched by out-of-order headers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            armed_q <= 1'b0;
            frame_q <= '0;
            exp_q   <= '0;
        end else if (cls != CLS_IDLE && cls != CLS_OOO) begin
            armed_q <= 1'b1;
            frame_q <= hdr_frame;
            exp_q   <= pkt_ext + 1'b1;
        end
    end

    // Event pulses, one cycle after the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            loss_q <= 1'b0;
            ooo_q  <= 1'b0;
        end else begin
            loss_q <= (cls == CLS_SKIP) ||
                      (cls == CLS_NEWFRAME && (pkt_inc != '0 || frm_inc != '0));
            ooo_q  <= (cls == CLS_OOO);
        end
    end

    // R2: the first header after reset or clear never signals an event.
    p_first_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !clr && !armed_q) |=> (!loss_q && !ooo_q));

    // R4: a loss pulse always follows an accepted header.
    p_loss_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        loss_q |-> $past(hdr_valid && !clr));

    // R7: a header is either a loss or out of order, never both.
    p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(loss_q && ooo_q));

    // R7: an out-of-order header leaves the expected packet number alone.
    p_ooo_keeps_exp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ooo_q |-> $stable(exp_q));

endmodule

// File: rtl/pkt_seq_monitor.sv
// Module: pkt_seq_monitor (top)
// Watches packet headers carrying a frame number and an in-frame packet
// number. It counts missing packets within frames that arrived, frames
// that are missing completely, and frames received. All counters saturate.
// Assumes one header at most per cycle and packet numbers below
// PKTS_PER_FRAME. Frame distance is taken modulo 2**FRAME_W.
module pkt_seq_monitor
    import pkt_mon_pkg::*;
#(
    parameter int FRAME_W        = 16,
    parameter int PKT_W          = 9,
    parameter int PKTS_PER_FRAME = 270,
    parameter int CNT_W          = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               hdr_valid,
    input  logic [FRAME_W-1:0] hdr_frame,
    input  logic [PKT_W-1:0]   hdr_pkt,
    output logic [CNT_W-1:0]   lost_pkt_cnt,
    output logic [CNT_W-1:0]   lost_frame_cnt,
    output logic [CNT_W-1:0]   rx_frame_cnt,
    output logic               loss_pulse,
    output logic               ooo_pulse
);
    localparam int PINC_W = PKT_W + 1;

    logic [PINC_W-1:0]  pkt_inc;
    logic [FRAME_W-1:0] frm_inc;
    logic               rx_inc;

    // Sequence tracking and header classification.
    pkt_seq_tracker #(
        .FRAME_W        (FRAME_W),
        .PKT_W          (PKT_W),
        .PKTS_PER_FRAME (PKTS_PER_FRAME)
    ) tracker_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .hdr_valid (hdr_valid),
        .hdr_frame (hdr_frame),
        .hdr_pkt   (hdr_pkt),
        .pkt_inc   (pkt_inc),
        .frm_inc   (frm_inc),
        .rx_inc    (rx_inc),
        .loss_q    (loss_pulse),
        .ooo_q     (ooo_pulse)
    );

    // Partial packet losses.
    pkt_sat_counter #(.CNT_W(CNT_W), .INC_W(PINC_W)) lost_pkt_i (
        .clk (clk), .rst_n (rst_n), .clr (clr),
        .inc (pkt_inc), .cnt (lost_pkt_cnt)
    );

    // Frames with nothing received.
    pkt_sat_counter #(.CNT_W(CNT_W), .INC_W(FRAME_W)) lost_frame_i (
        .clk (clk), .rst_n (rst_n), .clr (clr),
        .inc (frm_inc), .cnt (lost_frame_cnt)
    );

    // Frames with at least one packet.
    pkt_sat_counter #(.CNT_W(CNT_W), .INC_W(1)) rx_frame_i (
        .clk (clk), .rst_n (rst_n), .clr (clr),
        .inc (rx_inc), .cnt (rx_frame_cnt)
    );

    // R7: an out-of-order header moves no counter.
    p_ooo_no_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ooo_pulse |-> ($stable(lost_pkt_cnt) && $stable(lost_frame_cnt) &&
                       $stable(rx_frame_cnt)));

    // R6: complete frame losses only grow together with a received frame.
    p_frame_loss_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr) && lost_frame_cnt != $past(lost_frame_cnt)) |->
            (rx_frame_cnt != $past(rx_frame_cnt) || &rx_frame_cnt));

endmodule

// File: tb/pkt_seq_monitor_tb.sv
// Bench for pkt_seq_monitor in a small configuration: 4-bit frame field,
// 5 packets per frame, 5-bit counters. Expected values come from an
// arithmetic model of the requirements kept in the bench.
module pkt_seq_monitor_tb_top;
    localparam int FW   = 4;
    localparam int PW   = 3;
    localparam int NPK  = 5;
    localparam int CW   = 5;
    localparam int CMAX = 31;
    localparam int FMOD = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          hdr_valid = 1'b0;
    logic [FW-1:0] hdr_frame = '0;
    logic [PW-1:0] hdr_pkt = '0;
    logic [CW-1:0] lost_pkt_cnt, lost_frame_cnt, rx_frame_cnt;
    logic          loss_pulse, ooo_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Model state.
    int    m_lp = 0, m_lf = 0, m_rx = 0;
    bit    m_armed = 1'b0;
    int    m_frame = 0, m_exp = 0;
    bit    m_loss = 1'b0, m_ooo = 1'b0;
    string m_tag = "R1";

    always #10 clk = ~clk;

    pkt_seq_monitor #(
        .FRAME_W (FW), .PKT_W (PW), .PKTS_PER_FRAME (NPK), .CNT_W (CW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .clr (clr), .hdr_valid (hdr_valid),
        .hdr_frame (hdr_frame), .hdr_pkt (hdr_pkt),
        .lost_pkt_cnt (lost_pkt_cnt), .lost_frame_cnt (lost_frame_cnt),
        .rx_frame_cnt (rx_frame_cnt), .loss_pulse (loss_pulse),
        .ooo_pulse (ooo_pulse)
    );

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        cmp(m_tag, "lost_pkt_cnt", int'(lost_pkt_cnt), m_lp);
        cmp(m_tag, "lost_frame_cnt", int'(lost_frame_cnt), m_lf);
        cmp(m_tag, "rx_frame_cnt", int'(rx_frame_cnt), m_rx);
        cmp(m_tag, "loss_pulse", int'(loss_pulse), int'(m_loss));
        cmp(m_tag, "ooo_pulse", int'(ooo_pulse), int'(m_ooo));
    endtask

    // Model of one accepted header, following R2..R8.
    task automatic model_hdr(input int f, input int p);
        int k, lead_tail, raw;
        m_loss = 1'b0;
        m_ooo  = 1'b0;
        if (!m_armed) begin
            m_tag = "R2";
            m_armed = 1'b1; m_frame = f; m_exp = p + 1;
            m_rx = sat(m_rx + 1);
        end else if (f == m_frame) begin
            if (p == m_exp) begin
                m_tag = "R3"; m_exp = p + 1;
            end else if (p > m_exp) begin
                m_tag = "R4"; raw = m_lp + (p - m_exp);
                if (raw > CMAX) m_tag = "R8";
                m_lp = sat(raw); m_loss = 1'b1; m_exp = p + 1;
            end else begin
                m_tag = "R7"; m_ooo = 1'b1;
            end
        end else begin
            k = (f - m_frame + FMOD) % FMOD;
            lead_tail = (NPK - m_exp) + p;
            m_tag = (k > 1) ? "R6" : ((lead_tail != 0) ? "R5" : "R3");
            if (m_lp + lead_tail > CMAX || m_lf + k - 1 > CMAX || m_rx + 1 > CMAX)
                m_tag = "R8";
            m_lp = sat(m_lp + lead_tail);
            m_lf = sat(m_lf + k - 1);
            m_rx = sat(m_rx + 1);
            m_loss = (lead_tail != 0) || (k > 1);
            m_frame = f; m_exp = p + 1;
        end
    endtask

    task automatic send(input int f, input int p);
        @(negedge clk);
        hdr_valid = 1'b1;
        hdr_frame = FW'(f % FMOD);
        hdr_pkt   = PW'(p);
        model_hdr(f % FMOD, p);
        @(negedge clk);
        hdr_valid = 1'b0;
        check_all();
    endtask

    task automatic do_clear(input bit with_hdr);
        @(negedge clk);
        clr = 1'b1;
        hdr_valid = with_hdr;
        hdr_frame = FW'(9);
        hdr_pkt   = PW'(3);
        @(negedge clk);
        clr = 1'b0;
        hdr_valid = 1'b0;
        m_lp = 0; m_lf = 0; m_rx = 0; m_armed = 1'b0;
        m_loss = 1'b0; m_ooo = 1'b0; m_tag = "R9";
        check_all();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int fr;
        // R1: reset state.
        repeat (3) @(negedge clk);
        m_tag = "R1";
        check_all();
        rst_n = 1'b1;
        @(negedge clk);
        check_all();

        // R2: first header with non-zero packet number is not a loss.
        send(3, 2);
        // R3: in-order packets then a clean frame change.
        send(3, 3);
        send(3, 4);
        send(4, 0);
        send(4, 1);

        // R9: clear with a header in the same cycle; header discarded.
        do_clear(1'b1);
        send(7, 4);  // R2 again after clear

        // R5: every pairing of last-seen and first-seen packet.
        fr = 8;
        for (int a = 0; a < NPK; a++) begin
            for (int b = 0; b < NPK; b++) begin
                do_clear(1'b0);
                send(fr, 0);
                if (a > 0) send(fr, a);
                send(fr + 1, b);
                fr = (fr + 2) % FMOD;
            end
        end

        // R4 and R7: every skip distance inside a frame.
        for (int g = 0; g < NPK; g++) begin
            do_clear(1'b0);
            send(2, 0);
            send(2, 1);
            send(2, g);      // g<2: out of order, g==2 in order, g>2 skip
            send(2, (g < 2) ? 2 : ((g + 1 < NPK) ? g + 1 : g));
        end

        // R7: backward step followed by the expected packet.
        do_clear(1'b0);
        send(5, 0);
        send(5, 1);
        send(5, 2);
        send(5, 0);
        send(5, 3);

        // R6: frame jumps of every distance, including the wrap.
        for (int k = 1; k < FMOD; k++) begin
            do_clear(1'b0);
            send(14, 4);
            send(14 + k, 0);
        end

        // R8: drive all counters into saturation.
        do_clear(1'b0);
        send(0, 0);
        fr = 0;
        for (int i = 0; i < 40; i++) begin
            fr = (fr + 3) % FMOD;
            send(fr, 4);
        end
        send(fr, 4);        // same number again: out of order at saturation

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule